// File: doc/BRIEF.md
# Scaler Gate and Carry-Flag Controller

This block is the control section of one decimal scaler module. It decides whether the counting chain may accept pulses, it tells the counters when to clear, and it keeps a sticky overflow flag that software can read and that doubles as an interrupt request. Counting itself happens elsewhere. This block only produces the enable, the clear and the flag.

Start, stop and reset commands come from two places: the module's own front-panel style controls and a set of lines shared with other modules. A two-bit mode picks the source. In stand-alone mode the module listens to its own controls. In follower mode it listens to the shared lines. In leader mode it listens to its own controls and also repeats them onto outbound lines, so that followers move in step with it. Any of several inhibit lines closes the count gate at once, without changing the stored start/stop state.

The overflow pulse from the last decade sets the carry flag. The flag stays set through an ordinary counter reset. It clears only when a reset and a readout strobe arrive together. During a readout the flag is driven onto an active-low, open-drain style line, so the flags of many modules can share one wired-OR line.

Top module: `scaler_ctrl`

## Requirements
- R1: Mode codes on `mode_sel` are 0 = stand-alone, 1 = follower, 2 = leader, and 3 behaves as stand-alone. In follower mode `ext_start`, `ext_stop` and `ext_reset` are the routed commands. In the other modes `loc_start`, `loc_stop` and `loc_reset` are routed, and the unrouted set has no effect.
- R2: A routed start opens the gate state at the next clock edge, and a routed stop closes it at the next clock edge. When both arrive in the same cycle, stop wins. A routed reset does not change the gate state.
- R3: `count_en` is high exactly when the gate state is open and no bit of `inhibit` is high. Inhibit acts in the same cycle and does not alter the stored gate state.
- R4: `gate_lamp` equals `count_en` in every cycle.
- R5: `ctr_clear` equals the routed reset command in the same cycle.
- R6: An `ovf_pulse` sets `carry_flag` at the next clock edge.
- R7: `carry_flag` clears at the next clock edge only when the routed reset and `rd_strobe` are high in the same cycle. A routed reset without `rd_strobe`, and `rd_strobe` without a routed reset, leave the flag unchanged.
- R8: When `ovf_pulse` coincides with a clearing reset plus readout, the flag ends up set.
- R9: `carry_bus_n` is 0 exactly when `rd_strobe` and `carry_flag` are both 1. Otherwise it is released at 1.
- R10: In leader mode `lead_start`, `lead_stop` and `lead_reset` equal `loc_start`, `loc_stop` and `loc_reset` in the same cycle. In every other mode they are 0.
- R11: While `rst_n` is low, and until its synchronized release, the gate is closed and the carry flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Command routing mode |
| loc_start | input | 1 | Local start command |
| loc_stop | input | 1 | Local stop command |
| loc_reset | input | 1 | Local counter reset command |
| ext_start | input | 1 | Shared-line start command |
| ext_stop | input | 1 | Shared-line stop command |
| ext_reset | input | 1 | Shared-line reset command |
| inhibit | input | N_INH | Inhibit lines; any high bit closes the gate |
| ovf_pulse | input | 1 | Overflow from the last decade |
| rd_strobe | input | 1 | Readout strobe |
| count_en | output | 1 | Count gate enable to the counters |
| ctr_clear | output | 1 | Counter clear |
| gate_lamp | output | 1 | Gate-open indicator |
| carry_flag | output | 1 | Sticky carry flag / interrupt request |
| carry_bus_n | output | 1 | Active-low carry flag onto the shared readout line |
| lead_start | output | 1 | Start repeated to followers |
| lead_stop | output | 1 | Stop repeated to followers |
| lead_reset | output | 1 | Reset repeated to followers |

## Verification
Random cycles draw all four mode codes together with independent local and shared commands. This shows whether routing follows the mode and whether the unrouted set leaks through. Sparse overflow pulses combined with frequent readouts and resets separate a reset-only cycle, a readout-only cycle and a true clearing cycle. Directed cases check stop and start in the same cycle, an overflow coinciding with a clearing cycle, an inhibit pulse inside an open window, and the reserved mode code.

// File: rtl/scaler_ctrl_pkg.sv
package scaler_ctrl_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_ALONE  = 2'd0,
    MODE_FOLLOW = 2'd1,
    MODE_LEAD   = 2'd2,
    MODE_SPARE  = 2'd3
  } route_mode_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic reset;
  } cmd_t;
endpackage

// File: rtl/scaler_route.sv
module scaler_route
  import scaler_ctrl_pkg::*;
(
  input  logic [MODE_W-1:0] mode_sel,
  input  cmd_t              loc_cmd,
  input  cmd_t              ext_cmd,
  output cmd_t              sel_cmd,
  output cmd_t              lead_cmd
);
  route_mode_e mode;
  logic        use_ext;
  logic        is_lead;

  always_comb begin
    mode    = route_mode_e'(mode_sel);
    use_ext = 1'b0;
    is_lead = 1'b0;
    case (mode)
      MODE_FOLLOW: use_ext = 1'b1;
      MODE_LEAD:   is_lead = 1'b1;
      default:     use_ext = 1'b0;
    endcase
  end

  always_comb begin
    sel_cmd  = use_ext ? ext_cmd : loc_cmd;
    lead_cmd = is_lead ? loc_cmd : '0;
  end
endmodule

// File: rtl/scaler_gate.sv
module scaler_gate #(
  parameter int N_INH = 2
) (
  input  logic             clk,
  input  logic             rst_core_n,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic [N_INH-1:0] inhibit,
  output logic             count_en
);
  logic run_q;
  logic run_d;
  logic run_ce;
  logic any_inh;

  always_comb begin
    run_ce = start_cmd | stop_cmd;
    run_d  = ~stop_cmd;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)
      run_q <= 1'b0;
    else if (run_ce)
      run_q <= run_d;
  end

  always_comb begin
    any_inh  = |inhibit;
    count_en = run_q & ~any_inh;
  end
endmodule

// File: rtl/scaler_carry.sv
module scaler_carry (
  input  logic clk,
  input  logic rst_core_n,
  input  logic ovf_pulse,
  input  logic reset_cmd,
  input  logic rd_strobe,
  output logic carry_flag,
  output logic carry_bus_n
);
  logic flag_q;
  logic flag_d;
  logic flag_ce;
  logic clr_req;

  always_comb begin
    clr_req = reset_cmd & rd_strobe;
    flag_ce = ovf_pulse | clr_req;
    flag_d  = ovf_pulse;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)
      flag_q <= 1'b0;
    else if (flag_ce)
      flag_q <= flag_d;
  end

  always_comb begin
    carry_flag  = flag_q;
    carry_bus_n = ~(flag_q & rd_strobe);
  end
endmodule

// File: rtl/scaler_ctrl.sv
module scaler_ctrl
  import scaler_ctrl_pkg::*;
#(
  parameter int N_INH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             loc_start,
  input  logic             loc_stop,
  input  logic             loc_reset,
  input  logic             ext_start,
  input  logic             ext_stop,
  input  logic             ext_reset,
  input  logic [N_INH-1:0] inhibit,
  input  logic             ovf_pulse,
  input  logic             rd_strobe,
  output logic             count_en,
  output logic             ctr_clear,
  output logic             gate_lamp,
  output logic             carry_flag,
  output logic             carry_bus_n,
  output logic             lead_start,
  output logic             lead_stop,
  output logic             lead_reset
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_core_n;
  cmd_t                   loc_cmd;
  cmd_t                   ext_cmd;
  cmd_t                   sel_cmd;
  cmd_t                   lead_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_core_n = rst_pipe[SYNC_STAGES-1];

  always_comb begin
    loc_cmd = '{start: loc_start, stop: loc_stop, reset: loc_reset};
    ext_cmd = '{start: ext_start, stop: ext_stop, reset: ext_reset};
  end

  scaler_route u_route (
    .mode_sel (mode_sel),
    .loc_cmd  (loc_cmd),
    .ext_cmd  (ext_cmd),
    .sel_cmd  (sel_cmd),
    .lead_cmd (lead_cmd)
  );

  scaler_gate #(.N_INH(N_INH)) u_gate (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .start_cmd  (sel_cmd.start),
    .stop_cmd   (sel_cmd.stop),
    .inhibit    (inhibit),
    .count_en   (count_en)
  );

  scaler_carry u_carry (
    .clk         (clk),
    .rst_core_n  (rst_core_n),
    .ovf_pulse   (ovf_pulse),
    .reset_cmd   (sel_cmd.reset),
    .rd_strobe   (rd_strobe),
    .carry_flag  (carry_flag),
    .carry_bus_n (carry_bus_n)
  );

  always_comb begin
    ctr_clear  = sel_cmd.reset;
    gate_lamp  = count_en;
    lead_start = lead_cmd.start;
    lead_stop  = lead_cmd.stop;
    lead_reset = lead_cmd.reset;
  end
endmodule

// File: rtl/scaler_ctrl_chk.sv
module scaler_ctrl_chk #(
  parameter int N_INH = 2
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic [1:0]       mode_sel,
  input logic             loc_start,
  input logic             loc_stop,
  input logic             loc_reset,
  input logic             ext_reset,
  input logic [N_INH-1:0] inhibit,
  input logic             ovf_pulse,
  input logic             rd_strobe,
  input logic             count_en,
  input logic             ctr_clear,
  input logic             gate_lamp,
  input logic             carry_flag,
  input logic             carry_bus_n,
  input logic             lead_start,
  input logic             lead_stop,
  input logic             lead_reset
);
  // R1 / R5: the follower mode takes the shared reset
  assert_follow_route_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_sel == 2'd1) |-> (ctr_clear == ext_reset));

  // R2: a local stop in stand-alone mode leaves the gate shut
  assert_stop_closes_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_sel == 2'd0 && loc_stop) |=> !count_en);

  assert_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (|inhibit) |-> !count_en);

  assert_lamp_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    gate_lamp == count_en);

  assert_ovf_sets_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    ovf_pulse |=> carry_flag);

  assert_hold_no_read_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (carry_flag && !rd_strobe) |=> carry_flag);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (carry_flag && rd_strobe && ctr_clear && !ovf_pulse) |=> !carry_flag);

  assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rd_strobe |-> carry_bus_n);

  assert_read_bus_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_strobe && carry_flag) |-> !carry_bus_n);

  assert_lead_echo_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_sel == 2'd2) |-> (lead_start == loc_start && lead_stop == loc_stop
                            && lead_reset == loc_reset));

  assert_lead_quiet_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_sel != 2'd2) |-> !(lead_start || lead_stop || lead_reset));

  always_comb begin
    if (!rst_core_n) begin
      assert_reset_state_R11: assert (!carry_flag && !count_en);
    end
  end
endmodule

bind scaler_ctrl scaler_ctrl_chk #(.N_INH(N_INH)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .mode_sel    (mode_sel),
  .loc_start   (loc_start),
  .loc_stop    (loc_stop),
  .loc_reset   (loc_reset),
  .ext_reset   (ext_reset),
  .inhibit     (inhibit),
  .ovf_pulse   (ovf_pulse),
  .rd_strobe   (rd_strobe),
  .count_en    (count_en),
  .ctr_clear   (ctr_clear),
  .gate_lamp   (gate_lamp),
  .carry_flag  (carry_flag),
  .carry_bus_n (carry_bus_n),
  .lead_start  (lead_start),
  .lead_stop   (lead_stop),
  .lead_reset  (lead_reset)
);

// File: tb/tb_scaler_ctrl.sv
module tb_scaler_ctrl;
  localparam int  N_INH    = 2;
  localparam time CLK_PER  = 10ns;
  localparam int  N_RAND   = 600;
  localparam int  WDOG_CYC = 20000;

  logic             clk;
  logic             rst_n;
  logic [1:0]       mode_sel;
  logic             loc_start, loc_stop, loc_reset;
  logic             ext_start, ext_stop, ext_reset;
  logic [N_INH-1:0] inhibit;
  logic             ovf_pulse, rd_strobe;
  logic             count_en, ctr_clear, gate_lamp, carry_flag, carry_bus_n;
  logic             lead_start, lead_stop, lead_reset;

  int  n_checks;
  int  n_fail;
  bit  m_run;
  bit  m_flag;
  bit  done;

  scaler_ctrl #(.N_INH(N_INH)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .loc_start(loc_start), .loc_stop(loc_stop), .loc_reset(loc_reset),
    .ext_start(ext_start), .ext_stop(ext_stop), .ext_reset(ext_reset),
    .inhibit(inhibit), .ovf_pulse(ovf_pulse), .rd_strobe(rd_strobe),
    .count_en(count_en), .ctr_clear(ctr_clear), .gate_lamp(gate_lamp),
    .carry_flag(carry_flag), .carry_bus_n(carry_bus_n),
    .lead_start(lead_start), .lead_stop(lead_stop), .lead_reset(lead_reset)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  function automatic bit f_follow(input logic [1:0] m);
    return m == 2'd1;
  endfunction
  function automatic bit f_start();
    return f_follow(mode_sel) ? ext_start : loc_start;
  endfunction
  function automatic bit f_stop();
    return f_follow(mode_sel) ? ext_stop : loc_stop;
  endfunction
  function automatic bit f_reset();
    return f_follow(mode_sel) ? ext_reset : loc_reset;
  endfunction
  function automatic bit f_en();
    return m_run && (inhibit == '0);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    mode_sel = 2'd0;
    {loc_start, loc_stop, loc_reset} = '0;
    {ext_start, ext_stop, ext_reset} = '0;
    inhibit = '0; ovf_pulse = 1'b0; rd_strobe = 1'b0;
  endtask

  // inputs already driven after a falling edge; check, then advance model
  task automatic step();
    bit lead;
    #1;
    lead = (mode_sel == 2'd2);
    check("R3 count_en", count_en, f_en());
    check("R4 gate_lamp", gate_lamp, f_en());
    check("R5/R1 ctr_clear", ctr_clear, f_reset());
    check("R6/R7 carry_flag", carry_flag, m_flag);
    check("R9 carry_bus_n", carry_bus_n, !(rd_strobe && m_flag));
    check("R10 lead_start", lead_start, lead && loc_start);
    check("R10 lead_stop", lead_stop, lead && loc_stop);
    check("R10 lead_reset", lead_reset, lead && loc_reset);
    @(posedge clk);
    if (f_stop()) m_run = 1'b0;
    else if (f_start()) m_run = 1'b1;
    if (ovf_pulse) m_flag = 1'b1;
    else if (f_reset() && rd_strobe) m_flag = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < WDOG_CYC; c++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    m_run = 0; m_flag = 0;
    void'($urandom(32'd20240611));
    idle_inputs();
    rst_n = 1'b0;
    // R11: hostile inputs during reset must not open the gate or set the flag
    loc_start = 1'b1; ovf_pulse = 1'b1; rd_strobe = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R11 reset count_en", count_en, 1'b0);
    check("R11 reset carry_flag", carry_flag, 1'b0);
    check("R11 reset carry_bus_n", carry_bus_n, 1'b1);
    idle_inputs();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: start and stop together -> stop wins
    loc_start = 1; loc_stop = 1; step();
    idle_inputs(); step();
    // R2: start opens
    loc_start = 1; step();
    idle_inputs(); step();
    // R3: inhibit closes without touching state
    inhibit = 2'b10; step();
    idle_inputs(); step();
    // R2: routed reset does not close gate
    loc_reset = 1; step();
    idle_inputs(); step();
    // R1: in follower mode local stop ignored, shared stop acts
    mode_sel = 2'd1; loc_stop = 1; step();
    idle_inputs(); step();
    mode_sel = 2'd1; ext_stop = 1; step();
    idle_inputs(); step();
    // R1: reserved code 3 routes local
    mode_sel = 2'd3; loc_start = 1; ext_stop = 1; step();
    idle_inputs(); step();
    // R6, R7: set, reset alone, read alone, then clear
    ovf_pulse = 1; step();
    idle_inputs(); loc_reset = 1; step();
    idle_inputs(); rd_strobe = 1; step();
    idle_inputs(); loc_reset = 1; rd_strobe = 1; step();
    idle_inputs(); step();
    // R8: set wins over clear
    ovf_pulse = 1; loc_reset = 1; rd_strobe = 1; step();
    idle_inputs(); rd_strobe = 1; step();
    // R10: leader echo
    mode_sel = 2'd2; loc_start = 1; loc_reset = 1; step();
    idle_inputs(); step();

    for (int i = 0; i < N_RAND; i++) begin
      mode_sel  = 2'($urandom % 4);
      loc_start = ($urandom % 4) == 0;
      loc_stop  = ($urandom % 6) == 0;
      loc_reset = ($urandom % 6) == 0;
      ext_start = ($urandom % 4) == 0;
      ext_stop  = ($urandom % 6) == 0;
      ext_reset = ($urandom % 6) == 0;
      for (int b = 0; b < N_INH; b++) inhibit[b] = ($urandom % 5) == 0;
      ovf_pulse = ($urandom % 8) == 0;
      rd_strobe = ($urandom % 3) == 0;
      step();
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule